// File: doc/BRIEF.md
# SPI Flash Bank Address Extension Front End

This block sits on the device side of a single-bit SPI NOR flash whose array is larger than 16 MB. It watches chip select, serial clock and serial input, and decodes the command byte. For every read, program or erase command it builds the full 32-bit array address. It then presents that address on a parallel bus, together with a command class and a one-cycle start strobe, so that the array controller can act on it. Three ways reach the upper part of the array. First, an 8-bit bank register supplies address bits 25:24 for legacy three-byte commands. Second, a mode bit in that register makes the same legacy opcodes take four address bytes. Third, a set of dedicated opcodes always takes four address bytes.

The bank register is read with opcode 16h and written with opcode 17h. A register access can also be unlocked with the legacy opcode B9h: if B9h stands alone in its frame and the next frame is 01h, the first data byte of the 01h frame updates only the bank bits. During a read, the address advances once per eight serial clocks. It crosses bank boundaries and wraps to zero past the top of the array, and the bank register does not change.

The design samples SPI mode 0 signals with a faster system clock `clk`. Serial edges are found by comparing `sck` with its registered copy. Input bits are taken on rising edges, and output bits change on falling edges.

FSM states:
- `ST_OPCODE`: shift in the command byte.
- `ST_ADDR`: shift in 3 or 4 address bytes.
- `ST_STREAM`: read data phase with address increment.
- `ST_BAR_RD`: shift the bank register out.
- `ST_BAR_WR`: full register write.
- `ST_ARM`: B9h received, waiting for the frame to end.
- `ST_BANK_WR`: unlocked bank-bit write.
- `ST_SINK`: ignore bits until the frame ends.

FSM transitions:
- Chip select high from any state goes to `ST_OPCODE`.
- From `ST_OPCODE`, the 8th bit goes to `ST_ADDR` (address command), `ST_BAR_RD` (16h), `ST_BAR_WR` (17h), `ST_ARM` (B9h with the idle flag set), `ST_BANK_WR` (01h while unlocked and idle), or `ST_SINK` (anything else).
- From `ST_ADDR`, the last address bit goes to `ST_STREAM` for reads, or to `ST_SINK` otherwise.
- From `ST_BAR_WR` or `ST_BANK_WR`, the 8th bit goes to `ST_SINK`.
- From `ST_ARM`, any further bit goes to `ST_SINK`.

The unlock is set when a frame ends in `ST_ARM`. It is cleared when any other frame ends, and by the next decoded opcode.

Top module: `flash_bank_front`

## Requirements
- R1: After reset the bank register, `so`, `arr_addr` and `cmd_start` are all zero. Bits 6:2 of the bank register always read zero.
- R2: When bit 7 of the bank register is 0, the legacy opcodes take three address bytes, MSB first. The address is `{bank[1:0], addr[23:0]}`. The legacy opcodes are reads 03h, 0Bh, 3Bh, 6Bh, BBh and EBh; programs 02h and 32h; and erases D8h and 20h.
- R3: When bank register bit 7 is 1, the same legacy opcodes take four address bytes, and the bank bits are not used.
- R4: The opcodes 13h, 0Ch, 3Ch, 6Ch, BCh, ECh (read), 12h, 34h (program), DCh and 21h (erase) always take four address bytes, whatever bit 7 holds.
- R5: On the rising clock edge that takes the last address bit, `cmd_start` pulses for exactly one `clk` cycle. At the same time `arr_addr` is loaded, and `cmd_class` shows 1 for a read, 2 for a program or 3 for an erase.
- R6: Opcode 16h shifts the bank register out on `so`, MSB first, one bit per falling edge. The first bit appears on the falling edge after the opcode, and the byte repeats every 8 clocks.
- R7: Opcode 17h followed by one byte writes bit 7 and bits 1:0 of the bank register from that byte. Bits 6:2 are forced to zero. No write-enable is needed.
- R8: A frame holding only B9h, followed by a frame starting with 01h, loads bank bits 1:0 from the first data byte. Bit 7 and the other bits of the first data byte have no effect, and a second data byte is ignored.
- R9: If anything other than 01h follows B9h, the unlock is cancelled and a later 01h changes nothing. This includes a different opcode, or extra clocks in the B9h frame.
- R10: If `idle_ok` is low when B9h or the following 01h is decoded, the bank register is left unchanged.
- R11: In a read, `arr_addr` increases by one after every 8 data clocks and crosses 16 MB bank boundaries. The bank register stays unchanged.
- R12: `arr_addr` is masked to `ADDR_W` bits. A streaming read past the top address wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the SPI pins |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| si | input | 1 | SPI serial data in |
| idle_ok | input | 1 | High when the device is idle or suspended |
| so | output | 1 | SPI serial data out |
| arr_addr | output | 32 | Formed array address |
| cmd_class | output | 2 | 1 read, 2 program, 3 erase |
| cmd_start | output | 1 | One-cycle strobe: address and class are valid |
| bank_reg | output | 8 | Current bank register contents |

## Verification
A wrong address length shows up at once: the strobe fires 8 serial clocks early or late, with the address bytes shifted by one byte. A bank register that is corrupt, or unlocked when it should not be, is visible on `bank_reg` as soon as the frame that wrote it ends, and again on `so` during the next 16h read. A broken streaming counter or wrap mask shows on `arr_addr` within 8 serial clocks of the boundary.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_READ  = 2'd1,
        CLS_PROG  = 2'd2,
        CLS_ERASE = 2'd3
    } cls_e;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR,
        ST_STREAM,
        ST_BAR_RD,
        ST_BAR_WR,
        ST_ARM,
        ST_BANK_WR,
        ST_SINK
    } st_e;

    localparam logic [7:0] OP_BANK_RD   = 8'h16;
    localparam logic [7:0] OP_BANK_WR   = 8'h17;
    localparam logic [7:0] OP_UNLOCK    = 8'hB9;
    localparam logic [7:0] OP_REG_WRITE = 8'h01;

endpackage

// File: rtl/fbf_op_decode.sv
module fbf_op_decode
    import fbf_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic       ext_mode,
    output cls_e       cls,
    output logic       wide
);
    always_comb begin
        cls  = CLS_NONE;
        wide = 1'b0;
        case (opcode)
            8'h03, 8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB: begin cls = CLS_READ;  wide = ext_mode; end
            8'h02, 8'h32:                             begin cls = CLS_PROG;  wide = ext_mode; end
            8'hD8, 8'h20:                             begin cls = CLS_ERASE; wide = ext_mode; end
            8'h13, 8'h0C, 8'h3C, 8'h6C, 8'hBC, 8'hEC: begin cls = CLS_READ;  wide = 1'b1; end
            8'h12, 8'h34:                             begin cls = CLS_PROG;  wide = 1'b1; end
            8'hDC, 8'h21:                             begin cls = CLS_ERASE; wide = 1'b1; end
            default: begin cls = CLS_NONE; wide = 1'b0; end
        endcase
    end
endmodule

// File: rtl/fbf_addr_form.sv
module fbf_addr_form #(
    parameter int ADDR_W = 26
) (
    input  logic [31:0] raw,
    input  logic        wide,
    input  logic [1:0]  bank,
    output logic [31:0] addr
);
    localparam logic [31:0] MASK = 32'hFFFF_FFFF >> (32 - ADDR_W);

    always_comb begin
        if (wide)
            addr = raw & MASK;
        else
            addr = {6'd0, bank, raw[23:0]} & MASK;
    end
endmodule

// File: rtl/flash_bank_front.sv
module flash_bank_front
    import fbf_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        sck,
    input  logic        si,
    input  logic        idle_ok,
    output logic        so,
    output logic [31:0] arr_addr,
    output logic [1:0]  cmd_class,
    output logic        cmd_start,
    output logic [7:0]  bank_reg
);
    localparam logic [31:0] MASK = 32'hFFFF_FFFF >> (32 - ADDR_W);

    st_e         state, state_n;
    logic        sck_q, cs_q;
    logic        rise, fall, cs_end;
    logic [31:0] shreg;
    logic [5:0]  cnt;
    logic [7:0]  byte_in;
    logic [31:0] raw_in;
    cls_e        dec_cls, cls_q;
    logic        dec_wide, wide_q;
    logic        armed;
    logic [31:0] formed;
    logic        addr_last;

    assign rise      = ~cs_n & sck & ~sck_q;
    assign fall      = ~cs_n & ~sck & sck_q;
    assign cs_end    = cs_n & ~cs_q;
    assign byte_in   = {shreg[6:0], si};
    assign raw_in    = {shreg[30:0], si};
    assign addr_last = wide_q ? (cnt == 6'd31) : (cnt == 6'd23);

    fbf_op_decode u_dec (
        .opcode   (byte_in),
        .ext_mode (bank_reg[7]),
        .cls      (dec_cls),
        .wide     (dec_wide)
    );

    fbf_addr_form #(.ADDR_W(ADDR_W)) u_form (
        .raw  (raw_in),
        .wide (wide_q),
        .bank (bank_reg[1:0]),
        .addr (formed)
    );

    // next-state logic
    always_comb begin
        state_n = state;
        if (cs_n) begin
            state_n = ST_OPCODE;
        end else if (rise) begin
            unique case (state)
                ST_OPCODE: if (cnt[2:0] == 3'd7) begin
                    if (dec_cls != CLS_NONE)          state_n = ST_ADDR;
                    else if (byte_in == OP_BANK_RD)   state_n = ST_BAR_RD;
                    else if (byte_in == OP_BANK_WR)   state_n = ST_BAR_WR;
                    else if (byte_in == OP_UNLOCK)    state_n = idle_ok ? ST_ARM : ST_SINK;
                    else if (byte_in == OP_REG_WRITE) state_n = (armed && idle_ok) ? ST_BANK_WR : ST_SINK;
                    else                              state_n = ST_SINK;
                end
                ST_ADDR:    if (addr_last) state_n = (cls_q == CLS_READ) ? ST_STREAM : ST_SINK;
                ST_BAR_WR,
                ST_BANK_WR: if (cnt[2:0] == 3'd7) state_n = ST_SINK;
                ST_ARM:     state_n = ST_SINK;
                ST_STREAM,
                ST_BAR_RD,
                ST_SINK:    state_n = state;
                default:    state_n = ST_SINK;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OPCODE;
        else        state <= state_n;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q     <= 1'b0;
            cs_q      <= 1'b1;
            shreg     <= '0;
            cnt       <= '0;
            cls_q     <= CLS_NONE;
            wide_q    <= 1'b0;
            armed     <= 1'b0;
            bank_reg  <= 8'h00;
            arr_addr  <= '0;
            cmd_class <= 2'd0;
            cmd_start <= 1'b0;
            so        <= 1'b0;
        end else begin
            sck_q     <= sck;
            cs_q      <= cs_n;
            cmd_start <= 1'b0;
            if (cs_end)
                armed <= (state == ST_ARM);
            if (cs_n) begin
                cnt <= '0;
                so  <= 1'b0;
            end else if (rise) begin
                shreg <= raw_in;
                if (state == ST_BAR_RD)
                    cnt <= cnt;
                else if (state_n != state)
                    cnt <= '0;
                else
                    cnt <= cnt + 6'd1;
                unique case (state)
                    ST_OPCODE: if (cnt[2:0] == 3'd7) begin
                        cls_q  <= dec_cls;
                        wide_q <= dec_wide;
                        armed  <= 1'b0;
                    end
                    ST_ADDR: if (addr_last) begin
                        arr_addr  <= formed;
                        cmd_class <= cls_q;
                        cmd_start <= 1'b1;
                    end
                    ST_STREAM: if (cnt[2:0] == 3'd7)
                        arr_addr <= (arr_addr + 32'd1) & MASK;
                    ST_BAR_WR: if (cnt[2:0] == 3'd7)
                        bank_reg <= {byte_in[7], 5'd0, byte_in[1:0]};
                    ST_BANK_WR: if (cnt[2:0] == 3'd7)
                        bank_reg[1:0] <= byte_in[1:0];
                    ST_BAR_RD, ST_ARM, ST_SINK: ;
                    default: ;
                endcase
            end else if (fall && state == ST_BAR_RD) begin
                so  <= bank_reg[3'd7 - cnt[2:0]];
                cnt <= cnt + 6'd1;
            end
        end
    end

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bank_reg[6:2] == 5'd0);                                            // R1
    AST_START_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> (cmd_class != 2'd0));                                // R5
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start);                                         // R5
    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BANK_WR) |=> $stable(bank_reg[7]));                   // R8
    AST_STREAM_BAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM) |=> $stable(bank_reg));                       // R11
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_addr & ~MASK) == 32'd0);                                      // R12

endmodule

// File: tb/flash_bank_front_bench.sv
module flash_bank_front_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        si = 1'b0;
    logic        idle_ok = 1'b1;
    logic        so;
    logic [31:0] arr_addr;
    logic [1:0]  cmd_class;
    logic        cmd_start;
    logic [7:0]  bank_reg;

    int tests = 0;
    int fails = 0;
    int starts = 0;
    bit done = 0;

    always #5 clk = ~clk;

    flash_bank_front u_flash_bank_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .idle_ok(idle_ok), .so(so), .arr_addr(arr_addr),
        .cmd_class(cmd_class), .cmd_start(cmd_start), .bank_reg(bank_reg)
    );

    always @(posedge clk) if (cmd_start) starts++;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        sck = 1'b0; si = b; tick(2);
        sck = 1'b1; tick(2);
    endtask

    task automatic byte_out(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
    endtask

    task automatic bit_in(output logic b);
        sck = 1'b0; tick(2);
        b = so;
        sck = 1'b1; tick(2);
    endtask

    task automatic cs_lo();
        cs_n = 1'b0; tick(2);
    endtask

    task automatic cs_hi();
        sck = 1'b0; tick(2);
        cs_n = 1'b1; tick(3);
    endtask

    task automatic bar_write(input logic [7:0] v);
        cs_lo(); byte_out(8'h17); byte_out(v); cs_hi();
    endtask

    task automatic one_op(input logic [7:0] op);
        cs_lo(); byte_out(op); cs_hi();
    endtask

    task automatic addr_cmd(input string tag, input logic [7:0] op, input int nb,
                            input logic [31:0] a, input logic [31:0] exp_addr,
                            input logic [1:0] exp_cls);
        int s0;
        s0 = starts;
        cs_lo(); byte_out(op);
        for (int i = nb - 1; i >= 0; i--) byte_out(a[8*i +: 8]);
        check({tag, " addr"}, arr_addr, exp_addr);
        check({tag, " class"}, {30'd0, cmd_class}, {30'd0, exp_cls});
        check({tag, " one strobe"}, starts - s0, 1);
        cs_hi();
    endtask

    task automatic t_reset();
        check("R1 reset bank", {24'd0, bank_reg}, 32'h0);
        check("R1 reset so", {31'd0, so}, 32'h0);
        check("R1 reset addr", arr_addr, 32'h0);
        check("R1 reset strobe", {31'd0, cmd_start}, 32'h0);
    endtask

    task automatic t_bar_write();
        bar_write(8'h7F);
        check("R7 R1 write masks reserved", {24'd0, bank_reg}, 32'h03);
    endtask

    task automatic t_legacy3();
        addr_cmd("R2 read", 8'h03, 3, 32'h123456, 32'h03123456, 2'd1);
        addr_cmd("R2 prog", 8'h02, 3, 32'hABCDEF, 32'h03ABCDEF, 2'd2);
        addr_cmd("R5 erase", 8'h20, 3, 32'h001000, 32'h03001000, 2'd3);
    endtask

    task automatic t_bar_read();
        logic [15:0] got;
        logic b;
        cs_lo(); byte_out(8'h16);
        for (int i = 15; i >= 0; i--) begin bit_in(b); got[i] = b; end
        cs_hi();
        check("R6 bank read repeat", {16'd0, got}, 32'h0303);
    endtask

    task automatic t_stream();
        bar_write(8'h00);
        cs_lo(); byte_out(8'h0B);
        byte_out(8'hFF); byte_out(8'hFF); byte_out(8'hFE);
        check("R11 start", arr_addr, 32'h00FFFFFE);
        byte_out(8'h00);
        check("R11 step", arr_addr, 32'h00FFFFFF);
        byte_out(8'h00);
        check("R11 cross bank", arr_addr, 32'h01000000);
        check("R11 bank kept", {24'd0, bank_reg}, 32'h00);
        cs_hi();
    endtask

    task automatic t_wrap();
        bar_write(8'h03);
        cs_lo(); byte_out(8'h03);
        byte_out(8'hFF); byte_out(8'hFF); byte_out(8'hFF);
        check("R12 top", arr_addr, 32'h03FFFFFF);
        byte_out(8'h00);
        check("R12 wrap", arr_addr, 32'h00000000);
        cs_hi();
    endtask

    task automatic t_ext4();
        bar_write(8'h80);
        check("R7 ext set", {24'd0, bank_reg}, 32'h80);
        addr_cmd("R3 legacy read 4B", 8'h03, 4, 32'h01234567, 32'h01234567, 2'd1);
        addr_cmd("R3 legacy erase 4B", 8'hD8, 4, 32'h02000000, 32'h02000000, 2'd3);
    endtask

    task automatic t_ded4();
        bar_write(8'h02);
        addr_cmd("R4 read4", 8'h13, 4, 32'h03000004, 32'h03000004, 2'd1);
        addr_cmd("R4 prog4", 8'h12, 4, 32'h00000100, 32'h00000100, 2'd2);
        addr_cmd("R4 R12 erase4 mask", 8'h21, 4, 32'hFF000000, 32'h03000000, 2'd3);
    endtask

    task automatic t_bank_seq();
        bar_write(8'h80);
        idle_ok = 1'b1;
        one_op(8'hB9);
        cs_lo(); byte_out(8'h01); byte_out(8'hFE); byte_out(8'hFF); cs_hi();
        check("R8 bank bits only", {24'd0, bank_reg}, 32'h82);
    endtask

    task automatic t_bank_close();
        one_op(8'hB9);
        cs_lo(); byte_out(8'h05); byte_out(8'h00); cs_hi();
        cs_lo(); byte_out(8'h01); byte_out(8'h01); cs_hi();
        check("R9 closed by other cmd", {24'd0, bank_reg}, 32'h82);
    endtask

    task automatic t_bank_busy();
        idle_ok = 1'b0;
        one_op(8'hB9);
        cs_lo(); byte_out(8'h01); byte_out(8'h01); cs_hi();
        check("R10 busy ignored", {24'd0, bank_reg}, 32'h82);
        idle_ok = 1'b1;
        one_op(8'hB9);
        cs_lo(); byte_out(8'h01); byte_out(8'h01); cs_hi();
        check("R8 idle accepted", {24'd0, bank_reg}, 32'h81);
    endtask

    task automatic t_bank_extra();
        cs_lo(); byte_out(8'hB9); bit_out(1'b0); cs_hi();
        cs_lo(); byte_out(8'h01); byte_out(8'h02); cs_hi();
        check("R9 extra clocks no arm", {24'd0, bank_reg}, 32'h81);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(3);
        t_reset();
        t_bar_write();
        t_legacy3();
        t_bar_read();
        t_stream();
        t_wrap();
        t_ext4();
        t_ded4();
        t_bank_seq();
        t_bank_close();
        t_bank_busy();
        t_bank_extra();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule